// File: doc/BRIEF.md
# Split-Transaction Ordering Scheduler

This block sits in the egress path of a switch or root port. It takes in packet descriptors, each tagged as a posted request, a non-posted request or a completion and carrying a traffic class and a transaction ID. It keeps one queue per packet class and, on every cycle, decides which waiting packet may leave next through a valid/ready forwarding port.

The choice is not round-robin. A pass/no-pass rule matrix governs it, and the matrix applies only between packets of the same traffic class. A posted request is never overtaken within its class. Completions that share an ID keep their arrival order. Posted requests and completions always flow around a non-posted request that is stalled for credit. When the bridge strap is set, a posted request must go ahead of a completion in its class. Every entry records a global arrival stamp. Among the candidates that are legal and whose class has credit, the oldest one wins.

Top module: `txn_order_sched`

## Requirements
- R1: The enqueue kind code is 0 for posted, 1 for non-posted and 2 for completion. Code 3 is never accepted: `in_ready_o` stays low while it is presented.
- R2: No packet leaves ahead of an older posted request that has the same traffic class.
- R3: Completions with the same traffic class and transaction ID leave in arrival order.
- R4: When the oldest non-posted request has no credit, a younger posted request or completion that is otherwise legal and has credit is still offered. With posted credit and a non-empty posted queue, `out_valid_o` is high.
- R5: A packet is offered only while the credit flag of its class (`cred_i` bit = kind code) is high.
- R6: Among the legal, credited candidates, the one with the earliest arrival is offered.
- R7: While `bridge_mode_i` is high, a credited head posted request is offered before any completion of its traffic class, older or not. While it is low, the older of the two goes first.
- R8: Packets of different traffic classes do not constrain each other. A younger packet can leave while an older posted request of another class waits.
- R9: Each class queue holds DEPTH (default 8) entries. A descriptor is accepted exactly when its class queue is not full.
- R10: A packet is removed only in a cycle where `out_valid_o` and `out_ready_i` are both high. While ready is low, the offered packet stays.
- R11: After reset all queues are empty, `out_valid_o` is low and valid kinds are accepted.
- R12: Only the first four completion-queue entries are candidates. A completion further back waits even when nothing else blocks it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Descriptor offered |
| in_ready_o | output | 1 | Descriptor accepted this cycle if valid |
| in_kind_i | input | 2 | Class code (R1) |
| in_tc_i | input | TC_W | Traffic class |
| in_id_i | input | ID_W | Transaction ID |
| cred_i | input | 3 | Credit-available flag per class, indexed by kind code |
| bridge_mode_i | input | 1 | Traffic heads toward a legacy bus |
| out_valid_o | output | 1 | A packet is offered |
| out_ready_i | input | 1 | Downstream takes the offered packet |
| out_kind_o | output | 2 | Class code of offered packet |
| out_tc_o | output | TC_W | Traffic class of offered packet |
| out_id_o | output | ID_W | Transaction ID of offered packet |

## Verification
The bench goes after the cases where one wrong term in the rule matrix changes which packet leaves. A non-posted request or completion that overtakes a posted request of its own class would break producer/consumer ordering. A scheduler that waits behind a credit-starved non-posted head would stall forward traffic for no reason. Ignoring the bridge strap would let an older completion leave ahead of a posted request. A window that is too wide would let a fifth completion slip out. Tests with a full queue and a reserved kind code check acceptance. A reference model run every cycle catches any forbidden pass, any skipped mandatory bypass, and any choice that is not the oldest legal packet.

// File: rtl/tos_pkg.sv
package tos_pkg;
  parameter int TC_W  = 3;
  parameter int ID_W  = 5;
  parameter int SEQ_W = 16;

  typedef enum logic [1:0] {
    K_POST = 2'd0,
    K_NPR  = 2'd1,
    K_CPL  = 2'd2,
    K_RSVD = 2'd3
  } kind_e;

  typedef struct packed {
    logic [TC_W-1:0]  tc;
    logic [ID_W-1:0]  id;
    logic [SEQ_W-1:0] seq;
  } ent_t;

  // modular age compare: a arrived before b
  function automatic logic is_older(logic [SEQ_W-1:0] a, logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return d[SEQ_W-1];
  endfunction
endpackage

// File: rtl/tos_queue.sv
module tos_queue
  import tos_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  ent_t             push_ent_i,
  input  logic             pop_i,
  input  logic [IDX_W-1:0] pop_idx_i,
  output ent_t             ent_o [DEPTH],
  output logic             vld_o [DEPTH],
  output logic             full_o
);
  ent_t             q_r [DEPTH];
  ent_t             q_n [DEPTH];
  logic [CNT_W-1:0] cnt_r, cnt_n;

  always_comb begin
    q_n   = q_r;
    cnt_n = cnt_r;
    if (pop_i) begin
      for (int i = 0; i < DEPTH - 1; i++)
        if (i >= int'(pop_idx_i)) q_n[i] = q_r[i+1];
      cnt_n = cnt_n - 1'b1;
    end
    if (push_i) begin
      for (int i = 0; i < DEPTH; i++)
        if (CNT_W'(i) == cnt_n) q_n[i] = push_ent_i;
      cnt_n = cnt_n + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_r <= '0;
      for (int i = 0; i < DEPTH; i++) q_r[i] <= '0;
    end else begin
      cnt_r <= cnt_n;
      q_r   <= q_n;
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      ent_o[i] = q_r[i];
      vld_o[i] = CNT_W'(i) < cnt_r;
    end
  end

  assign full_o = (cnt_r == CNT_W'(DEPTH));
endmodule

// File: rtl/tos_elig.sv
module tos_elig
  import tos_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIN   = 4,
  localparam int NC   = 2 + WIN
) (
  input  ent_t             p_ent_i [DEPTH],
  input  logic             p_vld_i [DEPTH],
  input  ent_t             n_ent_i,
  input  logic             n_vld_i,
  input  ent_t             c_ent_i [WIN],
  input  logic             c_vld_i [WIN],
  input  logic [2:0]       cred_i,
  input  logic             bridge_i,
  output logic             cand_vld_o [NC],
  output logic [SEQ_W-1:0] cand_seq_o [NC]
);
  logic n_blk;
  logic c_blk [WIN];
  logic c_dup [WIN];
  logic p_go;

  // older posted of the same class blocks everyone
  always_comb begin
    n_blk = 1'b0;
    for (int j = 0; j < DEPTH; j++)
      if (p_vld_i[j] && p_ent_i[j].tc == n_ent_i.tc && is_older(p_ent_i[j].seq, n_ent_i.seq))
        n_blk = 1'b1;
    for (int k = 0; k < WIN; k++) begin
      c_blk[k] = 1'b0;
      c_dup[k] = 1'b0;
      for (int j = 0; j < DEPTH; j++)
        if (p_vld_i[j] && p_ent_i[j].tc == c_ent_i[k].tc &&
            is_older(p_ent_i[j].seq, c_ent_i[k].seq))
          c_blk[k] = 1'b1;
      for (int j = 0; j < k; j++)
        if (c_vld_i[j] && c_ent_i[j].tc == c_ent_i[k].tc && c_ent_i[j].id == c_ent_i[k].id)
          c_dup[k] = 1'b1;
    end
  end

  assign p_go = p_vld_i[0] && cred_i[0];

  always_comb begin
    cand_vld_o[0] = p_go;
    cand_seq_o[0] = p_ent_i[0].seq;
    cand_vld_o[1] = n_vld_i && cred_i[1] && !n_blk;
    cand_seq_o[1] = n_ent_i.seq;
    for (int k = 0; k < WIN; k++) begin
      cand_vld_o[2+k] = c_vld_i[k] && cred_i[2] && !c_blk[k] && !c_dup[k] &&
                        !(bridge_i && p_go && p_ent_i[0].tc == c_ent_i[k].tc);
      cand_seq_o[2+k] = c_ent_i[k].seq;
    end
  end
endmodule

// File: rtl/tos_arb.sv
module tos_arb
  import tos_pkg::*;
#(
  parameter int NC = 6,
  localparam int SEL_W = $clog2(NC)
) (
  input  logic             cand_vld_i [NC],
  input  logic [SEQ_W-1:0] cand_seq_i [NC],
  output logic             sel_vld_o,
  output logic [SEL_W-1:0] sel_idx_o
);
  logic [SEQ_W-1:0] best_seq;

  always_comb begin
    sel_vld_o = 1'b0;
    sel_idx_o = '0;
    best_seq  = '0;
    for (int i = 0; i < NC; i++)
      if (cand_vld_i[i] && (!sel_vld_o || is_older(cand_seq_i[i], best_seq))) begin
        sel_vld_o = 1'b1;
        sel_idx_o = SEL_W'(i);
        best_seq  = cand_seq_i[i];
      end
  end
endmodule

// File: rtl/txn_order_sched.sv
module txn_order_sched
  import tos_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIN   = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [1:0]      in_kind_i,
  input  logic [TC_W-1:0] in_tc_i,
  input  logic [ID_W-1:0] in_id_i,
  input  logic [2:0]      cred_i,
  input  logic            bridge_mode_i,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [1:0]      out_kind_o,
  output logic [TC_W-1:0] out_tc_o,
  output logic [ID_W-1:0] out_id_o
);
  localparam int NC    = 2 + WIN;
  localparam int SEL_W = $clog2(NC);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  ent_t             q_ent [3][DEPTH];
  logic             q_vld [3][DEPTH];
  logic [3:0]       q_full;
  logic [2:0]       q_push, q_pop;
  logic [IDX_W-1:0] q_pidx [3];
  logic [SEQ_W-1:0] seq_r;
  ent_t             new_ent;
  logic             acc_in, fire;

  ent_t             c_ent [WIN];
  logic             c_vld [WIN];
  logic             cand_vld [NC];
  logic [SEQ_W-1:0] cand_seq [NC];
  logic             sel_vld;
  logic [SEL_W-1:0] sel_idx;
  logic [IDX_W-1:0] cpl_idx;

  assign q_full[3]  = 1'b1;
  assign in_ready_o = !q_full[in_kind_i];
  assign acc_in     = in_valid_i && in_ready_o;
  assign new_ent    = '{tc: in_tc_i, id: in_id_i, seq: seq_r};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     seq_r <= '0;
    else if (acc_in) seq_r <= seq_r + 1'b1;
  end

  for (genvar g = 0; g < 3; g++) begin : g_q
    assign q_push[g] = acc_in && in_kind_i == 2'(g);
    assign q_pop[g]  = fire && out_kind_o == 2'(g);
    assign q_pidx[g] = (g == 2) ? cpl_idx : '0;
    tos_queue #(.DEPTH(DEPTH)) u_q (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .push_i     (q_push[g]),
      .push_ent_i (new_ent),
      .pop_i      (q_pop[g]),
      .pop_idx_i  (q_pidx[g]),
      .ent_o      (q_ent[g]),
      .vld_o      (q_vld[g]),
      .full_o     (q_full[g])
    );
  end

  for (genvar k = 0; k < WIN; k++) begin : g_win
    assign c_ent[k] = q_ent[2][k];
    assign c_vld[k] = q_vld[2][k];
  end

  tos_elig #(.DEPTH(DEPTH), .WIN(WIN)) u_elig (
    .p_ent_i    (q_ent[0]),
    .p_vld_i    (q_vld[0]),
    .n_ent_i    (q_ent[1][0]),
    .n_vld_i    (q_vld[1][0]),
    .c_ent_i    (c_ent),
    .c_vld_i    (c_vld),
    .cred_i     (cred_i),
    .bridge_i   (bridge_mode_i),
    .cand_vld_o (cand_vld),
    .cand_seq_o (cand_seq)
  );

  tos_arb #(.NC(NC)) u_arb (
    .cand_vld_i (cand_vld),
    .cand_seq_i (cand_seq),
    .sel_vld_o  (sel_vld),
    .sel_idx_o  (sel_idx)
  );

  assign cpl_idx     = IDX_W'(sel_idx - SEL_W'(2));
  assign out_valid_o = sel_vld;
  assign fire        = sel_vld && out_ready_i;

  always_comb begin
    if (sel_idx == SEL_W'(0)) begin
      out_kind_o = K_POST;
      out_tc_o   = q_ent[0][0].tc;
      out_id_o   = q_ent[0][0].id;
    end else if (sel_idx == SEL_W'(1)) begin
      out_kind_o = K_NPR;
      out_tc_o   = q_ent[1][0].tc;
      out_id_o   = q_ent[1][0].id;
    end else begin
      out_kind_o = K_CPL;
      out_tc_o   = c_ent[cpl_idx].tc;
      out_id_o   = c_ent[cpl_idx].id;
    end
  end
endmodule

// File: rtl/tos_checker.sv
module tos_checker #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_valid_i,
  input logic       in_ready_o,
  input logic [1:0] in_kind_i,
  input logic [2:0] cred_i,
  input logic       out_valid_o,
  input logic       out_ready_i,
  input logic [1:0] out_kind_o
);
  logic [CNT_W-1:0] occ [4];
  logic [3:0]       cred_x;
  logic             in_full, all_empty;

  assign cred_x    = {1'b0, cred_i};
  assign in_full   = (occ[in_kind_i] == CNT_W'(DEPTH));
  assign all_empty = (occ[0] == '0) && (occ[1] == '0) && (occ[2] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 4; i++) occ[i] <= '0;
    end else begin
      for (int i = 0; i < 3; i++)
        occ[i] <= occ[i]
                  + CNT_W'(in_valid_i && in_ready_o && in_kind_i == 2'(i))
                  - CNT_W'(out_valid_o && out_ready_i && out_kind_o == 2'(i));
    end
  end

  p_rsvd_kind_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_kind_i == 2'd3 |-> !in_ready_o);
  p_credit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> cred_x[out_kind_o]);
  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_kind_i != 2'd3 && in_full) |-> !in_ready_o);
  p_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_kind_i != 2'd3 && !in_full) |-> in_ready_o);
  p_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_empty |-> !out_valid_o);
  p_posted_flows_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ[0] != '0 && cred_i[0]) |-> out_valid_o);
endmodule

bind txn_order_sched tos_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_kind_i   (in_kind_i),
  .cred_i      (cred_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_kind_o  (out_kind_o)
);

// File: tb/txn_order_sched_tb.sv
module txn_order_sched_tb;
  import tos_pkg::*;
  localparam int DEPTH = 8;
  localparam int WIN   = 4;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            in_valid_i = 1'b0;
  logic            in_ready_o;
  logic [1:0]      in_kind_i = 2'd0;
  logic [TC_W-1:0] in_tc_i = '0;
  logic [ID_W-1:0] in_id_i = '0;
  logic [2:0]      cred_i = 3'b111;
  logic            bridge_mode_i = 1'b0;
  logic            out_valid_o;
  logic            out_ready_i = 1'b1;
  logic [1:0]      out_kind_o;
  logic [TC_W-1:0] out_tc_o;
  logic [ID_W-1:0] out_id_o;

  always #2.5 clk_i = ~clk_i;

  txn_order_sched #(.DEPTH(DEPTH), .WIN(WIN)) u_dut (.*);

  typedef struct { int kind; int tc; int id; } pkt_t;
  pkt_t mq[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int cnt_kind(int k);
    int c = 0;
    foreach (mq[i]) if (mq[i].kind == k) c++;
    return c;
  endfunction

  // reference: scan in arrival order, first legal credited packet wins
  function automatic int pick();
    int ph = -1, nh = -1, ncpl = 0;
    foreach (mq[i]) if (mq[i].kind == 0) begin ph = i; break; end
    foreach (mq[i]) if (mq[i].kind == 1) begin nh = i; break; end
    foreach (mq[i]) begin
      bit ok, blk = 0;
      if (!cred_i[mq[i].kind]) ok = 0;
      else if (mq[i].kind == 0) ok = (i == ph);
      else if (mq[i].kind == 1) ok = (i == nh);
      else begin
        ok = (ncpl < WIN);
        for (int j = 0; j < i; j++)
          if (mq[j].kind == 2 && mq[j].tc == mq[i].tc && mq[j].id == mq[i].id) ok = 0;
        if (bridge_mode_i && ph >= 0 && cred_i[0] && mq[ph].tc == mq[i].tc) ok = 0;
      end
      for (int j = 0; j < i; j++)
        if (mq[j].kind == 0 && mq[j].tc == mq[i].tc) blk = 1;
      if (mq[i].kind == 2) ncpl++;
      if (ok && !blk) return i;
    end
    return -1;
  endfunction

  task automatic step(string tag);
    int  sel;
    bit  er, acc_i, acc_o;
    @(negedge clk_i); #1;
    er  = (in_kind_i != 2'd3) && cnt_kind(int'(in_kind_i)) < DEPTH;
    sel = pick();
    chk(in_ready_o == er, tag, "in_ready", int'(in_ready_o), int'(er));
    chk(out_valid_o == (sel >= 0), tag, "out_valid", int'(out_valid_o), int'(sel >= 0));
    if (sel >= 0 && out_valid_o) begin
      chk(int'(out_kind_o) == mq[sel].kind, tag, "out_kind", int'(out_kind_o), mq[sel].kind);
      chk(int'(out_tc_o) == mq[sel].tc, tag, "out_tc", int'(out_tc_o), mq[sel].tc);
      chk(int'(out_id_o) == mq[sel].id, tag, "out_id", int'(out_id_o), mq[sel].id);
    end
    acc_i = in_valid_i && er;
    acc_o = (sel >= 0) && out_ready_i;
    @(posedge clk_i); #1;
    if (acc_o) mq.delete(sel);
    if (acc_i) mq.push_back('{int'(in_kind_i), int'(in_tc_i), int'(in_id_i)});
  endtask

  task automatic enq(int k, int tc, int id, string tag);
    in_valid_i = 1; in_kind_i = 2'(k); in_tc_i = TC_W'(tc); in_id_i = ID_W'(id);
    step(tag);
    in_valid_i = 0;
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic drain(string tag);
    cred_i = 3'b111; out_ready_i = 1; bridge_mode_i = 0; in_valid_i = 0;
    for (int i = 0; i < 100 && mq.size() > 0; i++) step(tag);
    chk(mq.size() == 0, tag, "drained", mq.size(), 0);
  endtask

  initial begin
    #10000000;
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    run(2, "R11");

    in_valid_i = 1; in_kind_i = 2'd3; step("R1"); step("R1"); in_valid_i = 0; in_kind_i = 0;

    // fill posted queue with no credit
    cred_i = 3'b000; out_ready_i = 0;
    for (int i = 0; i < DEPTH + 2; i++) enq(0, i % 2, i, "R9");
    enq(1, 0, 1, "R9");
    drain("R9");

    cred_i = 3'b000;
    enq(0, 1, 1, "R5"); enq(1, 2, 2, "R5"); enq(2, 3, 3, "R5");
    run(3, "R5");
    cred_i = 3'b100; run(3, "R5"); cred_i = 3'b010; run(3, "R5"); cred_i = 3'b001; run(3, "R5");
    drain("R5");

    cred_i = 3'b110;
    enq(0, 0, 1, "R2"); enq(1, 0, 2, "R2"); enq(2, 0, 3, "R2");
    run(4, "R2");
    drain("R2");

    cred_i = 3'b110;
    enq(0, 0, 1, "R8"); enq(2, 1, 2, "R8"); enq(1, 2, 3, "R8");
    run(4, "R8");
    drain("R8");

    cred_i = 3'b101;
    enq(1, 0, 1, "R4"); enq(0, 0, 2, "R4"); enq(2, 0, 3, "R4"); enq(2, 1, 4, "R4");
    run(5, "R4");
    drain("R4");

    out_ready_i = 0;
    enq(1, 1, 1, "R6"); enq(0, 0, 2, "R6"); enq(2, 2, 3, "R6"); enq(1, 0, 4, "R6");
    out_ready_i = 1; run(5, "R6");
    drain("R6");

    out_ready_i = 0;
    enq(2, 0, 4, "R3"); enq(2, 1, 4, "R3"); enq(2, 0, 4, "R3"); enq(2, 0, 5, "R3"); enq(2, 0, 4, "R3");
    out_ready_i = 1; run(6, "R3");
    drain("R3");

    out_ready_i = 0; bridge_mode_i = 1;
    enq(2, 0, 6, "R7"); enq(0, 0, 7, "R7"); enq(2, 1, 8, "R7");
    out_ready_i = 1; run(4, "R7");
    out_ready_i = 0; bridge_mode_i = 0;
    enq(2, 0, 6, "R7"); enq(0, 0, 7, "R7");
    out_ready_i = 1; run(3, "R7");
    drain("R7");

    cred_i = 3'b110;
    enq(0, 0, 1, "R12");
    for (int i = 0; i < WIN; i++) enq(2, 0, i, "R12");
    enq(2, 1, 9, "R12");
    run(3, "R12");
    drain("R12");

    out_ready_i = 0;
    enq(1, 0, 1, "R10"); enq(2, 1, 2, "R10");
    run(4, "R10");
    drain("R10");

    for (int seg = 0; seg < 40; seg++) begin
      bridge_mode_i = $urandom_range(0, 1);
      for (int c = 0; c < 100; c++) begin
        in_valid_i  = $urandom_range(0, 3) != 0;
        in_kind_i   = 2'($urandom_range(0, 2));
        if ($urandom_range(0, 31) == 0) in_kind_i = 2'd3;
        in_tc_i     = TC_W'($urandom_range(0, 1));
        in_id_i     = ID_W'($urandom_range(0, 3));
        cred_i      = 3'($urandom_range(0, 7));
        out_ready_i = $urandom_range(0, 3) != 0;
        step("R6");
      end
      drain("R6");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule